// File: doc/BRIEF.md
# Single-Bus Accumulator Processor Core

This block is a complete small processor. It has one 32-word by 8-bit memory that holds both code and data. Its state is a 5-bit program counter, an 8-bit instruction register, a 5-bit address register, two operand latches and an 8-bit accumulator. Every instruction goes through the same eight steps, in this order:

1. Copy the program counter into the address register.
2. Fetch the instruction word.
3. Increment the program counter.
4. Point the address register at the operand.
5. Capture the operand word in the first latch.
6. Capture the accumulator in the second latch.
7. Execute.
8. Idle.

A host fills the memory through a write port while it holds the core in reset. The host then releases reset, and the core runs from address 0 until it meets a halt instruction. Once the core has halted, the host reads the accumulator and reads any memory word through a combinational read-back port. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `acc_core`

## Requirements
- R1: While the core is held in reset, a cycle with `load_we` high writes `load_data` into the word at `load_addr`. `rd_data` always shows the word at `rd_addr` combinationally.
- R2: `load_we` is ignored once the core is out of reset, including after a halt. Memory contents are unchanged.
- R3: During reset the accumulator reads 0 and `halted` reads 0. Execution begins at address 0.
- R4: An instruction word holds the opcode in bits 7:5 and the operand address in bits 4:0. The opcodes are 000 load, 001 store, 010 add, 011 invert, 100 branch-if-not-negative, 101 shift left, 110 shift right and 111 halt.
- R5: Load copies the operand word into the accumulator. Store writes the accumulator into the operand word.
- R6: Add sets the accumulator to operand plus accumulator, modulo 256, with no carry kept.
- R7: Invert sets the accumulator to the bitwise inverse of the operand word.
- R8: Shift left sets the accumulator to the operand shifted left by one, with a 0 filling bit 0. Shift right sets it to the operand shifted right by one, with bit 7 kept.
- R9: Branch loads the program counter with the operand address when accumulator bit 7 is 0. Otherwise execution continues at the next word.
- R10: Halt sets the program counter to 31 and raises `halted`. `halted`, the accumulator and memory then stay frozen until the next reset.
- R11: Each instruction takes 8 cycles. After `rst_n` rises, the halt instruction executed k-th (counting from 0) raises `halted` after clock edge 9+8k.
- R12: The program counter increments modulo 32, so the word after address 31 is address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| load_we | input | 1 | Write strobe for loading the memory image during reset |
| load_addr | input | 5 | Word address for the load port |
| load_data | input | 8 | Word value for the load port |
| rd_addr | input | 5 | Read-back address |
| rd_data | output | 8 | Memory word at `rd_addr` |
| halted | output | 1 | High once a halt instruction has executed |
| acc | output | 8 | Accumulator value |

## Verification
The arithmetic opcodes run on random operand pairs inside a load, operate, store, halt program. This shows that every opcode decodes to its own function and that results reach both the accumulator and memory. Directed cases then target specific behaviour:
- An add that overflows shows the result wraps modulo 256.
- A shift of 0x81 shows the shift-right sign fill and the loss of bit 7 on a shift left.
- Branch programs with a negative and a non-negative accumulator tell the taken path from the fall-through.
- A jump to address 30 that runs past 31 shows the counter wrap.
- Load-port writes after a halt show that the write port is blocked and the state is frozen.

Cycle counts to halt check the eight-step timing.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_LDA = 3'd0,
    OP_STA = 3'd1,
    OP_ADD = 3'd2,
    OP_CMP = 3'd3,
    OP_BNN = 3'd4,
    OP_SHL = 3'd5,
    OP_SHR = 3'd6,
    OP_HLT = 3'd7
  } opcode_e;

  typedef enum logic [2:0] {
    PH_MAR_PC = 3'd0,
    PH_IR_LD  = 3'd1,
    PH_PC_INC = 3'd2,
    PH_MAR_OP = 3'd3,
    PH_LAT1   = 3'd4,
    PH_LAT2   = 3'd5,
    PH_EXEC   = 3'd6,
    PH_IDLE   = 3'd7
  } phase_e;

endpackage

// File: rtl/acc_core_seq.sv
module acc_core_seq
  import acc_core_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   step_en,
  output phase_e phase
);

  phase_e ph_q;
  phase_e ph_d;

  // eight-step cycle, wraps from idle back to the first step
  always_comb begin
    ph_d = phase_e'(ph_q + 3'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_MAR_PC;
    end else if (step_en) begin
      ph_q <= ph_d;
    end
  end

  assign phase = ph_q;

endmodule

// File: rtl/acc_core_alu.sv
module acc_core_alu
  import acc_core_pkg::*;
#(
  parameter int W = 8
) (
  input  opcode_e      op,
  input  logic [W-1:0] lat1,
  input  logic [W-1:0] lat2,
  output logic [W-1:0] result,
  output logic         acc_wr
);

  always_comb begin
    result = lat1;
    acc_wr = 1'b1;
    case (op)
      OP_LDA:  result = lat1;
      OP_ADD:  result = lat1 + lat2;
      OP_CMP:  result = ~lat1;
      OP_SHL:  result = {lat1[W-2:0], 1'b0};
      OP_SHR:  result = {lat1[W-1], lat1[W-1:1]};
      default: acc_wr = 1'b0;
    endcase
  end

endmodule

// File: rtl/acc_core_mem.sv
module acc_core_mem #(
  parameter int W  = 8,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [W-1:0]  ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [W-1:0]  rb_data
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      arr[waddr] <= wdata;
    end
  end

  assign ra_data = arr[ra_addr];
  assign rb_data = arr[rb_addr];

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = ADDR_W + OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_we,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              halted,
  output logic [DATA_W-1:0] acc
);

  localparam logic [ADDR_W-1:0] HALT_PC = '1;
  localparam int                SIGN_B  = DATA_W - 1;

  // reset synchronizer: assert at once, release after two edges
  logic [1:0] rst_sync_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_ns = rst_sync_q[1];

  // architectural state
  logic [ADDR_W-1:0] pc_q, pc_d, mar_q, mar_d;
  logic [DATA_W-1:0] ir_q, ir_d, lat1_q, lat1_d, lat2_q, lat2_d, acc_q, acc_d;
  logic              halted_q;
  logic              pc_en, mar_en, ir_en, lat1_en, lat2_en, acc_en, halt_en;
  logic              core_we;

  phase_e            phase;
  opcode_e           op;
  logic [DATA_W-1:0] mem_rd;
  logic [DATA_W-1:0] alu_res;
  logic              alu_wr;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;

  assign op = opcode_e'(ir_q[DATA_W-1 -: OP_W]);

  acc_core_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_ns),
    .step_en (!halted_q),
    .phase   (phase)
  );

  acc_core_alu #(.W(DATA_W)) u_alu (
    .op     (op),
    .lat1   (lat1_q),
    .lat2   (lat2_q),
    .result (alu_res),
    .acc_wr (alu_wr)
  );

  // load port only reaches memory while the core is held in reset
  assign mem_we    = core_we | (load_we & !rst_ns);
  assign mem_waddr = core_we ? mar_q : load_addr;
  assign mem_wdata = core_we ? acc_q : load_data;

  acc_core_mem #(.W(DATA_W), .AW(ADDR_W)) u_mem (
    .clk     (clk),
    .we      (mem_we),
    .waddr   (mem_waddr),
    .wdata   (mem_wdata),
    .ra_addr (mar_q),
    .ra_data (mem_rd),
    .rb_addr (rd_addr),
    .rb_data (rd_data)
  );

  // next-state and enables
  always_comb begin
    pc_d    = pc_q + 1'b1;
    mar_d   = pc_q;
    ir_d    = mem_rd;
    lat1_d  = mem_rd;
    lat2_d  = acc_q;
    acc_d   = alu_res;
    pc_en   = 1'b0;
    mar_en  = 1'b0;
    ir_en   = 1'b0;
    lat1_en = 1'b0;
    lat2_en = 1'b0;
    acc_en  = 1'b0;
    halt_en = 1'b0;
    core_we = 1'b0;
    if (!halted_q) begin
      case (phase)
        PH_MAR_PC: mar_en  = 1'b1;
        PH_IR_LD:  ir_en   = 1'b1;
        PH_PC_INC: pc_en   = 1'b1;
        PH_MAR_OP: begin
          mar_d  = ir_q[ADDR_W-1:0];
          mar_en = 1'b1;
        end
        PH_LAT1:   lat1_en = 1'b1;
        PH_LAT2:   lat2_en = 1'b1;
        PH_EXEC: begin
          case (op)
            OP_STA: core_we = 1'b1;
            OP_BNN: begin
              pc_d  = ir_q[ADDR_W-1:0];
              pc_en = !acc_q[SIGN_B];
            end
            OP_HLT: begin
              pc_d    = HALT_PC;
              pc_en   = 1'b1;
              halt_en = 1'b1;
            end
            default: acc_en = alu_wr;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      pc_q     <= '0;
      mar_q    <= '0;
      ir_q     <= '0;
      lat1_q   <= '0;
      lat2_q   <= '0;
      acc_q    <= '0;
      halted_q <= 1'b0;
    end else begin
      if (pc_en)   pc_q     <= pc_d;
      if (mar_en)  mar_q    <= mar_d;
      if (ir_en)   ir_q     <= ir_d;
      if (lat1_en) lat1_q   <= lat1_d;
      if (lat2_en) lat2_q   <= lat2_d;
      if (acc_en)  acc_q    <= acc_d;
      if (halt_en) halted_q <= 1'b1;
    end
  end

  assign halted = halted_q;
  assign acc    = acc_q;

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_ns)
    halted_q |=> halted_q); // R10
  AST_HALT_PC_TOP: assert property (@(posedge clk) disable iff (!rst_ns)
    halted_q |-> (pc_q == HALT_PC)); // R10
  AST_ACC_EXEC_ONLY: assert property (@(posedge clk) disable iff (!rst_ns)
    (phase != PH_EXEC) |=> $stable(acc_q)); // R11
  AST_IR_FETCH_ONLY: assert property (@(posedge clk) disable iff (!rst_ns)
    (phase != PH_IR_LD) |=> $stable(ir_q)); // R11
  AST_PC_WRAP_STEP: assert property (@(posedge clk) disable iff (!rst_ns)
    (phase == PH_PC_INC && !halted_q) |=> (pc_q == ADDR_W'($past(pc_q) + 1'b1))); // R12

endmodule

// File: tb/acc_core_bench.sv
module acc_core_bench;
  import acc_core_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       load_we;
  logic [4:0] load_addr;
  logic [7:0] load_data;
  logic [4:0] rd_addr;
  logic [7:0] rd_data;
  logic       halted;
  logic [7:0] acc;

  always #10 clk = ~clk;

  acc_core u_acc_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_we   (load_we),
    .load_addr (load_addr),
    .load_data (load_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .halted    (halted),
    .acc       (acc)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] img [32];

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] enc(input opcode_e op, input int a);
    logic [4:0] a5;
    a5 = a[4:0];
    return {op, a5};
  endfunction

  // expected accumulator after "load a; op b"
  function automatic logic [7:0] model(input opcode_e op, input logic [7:0] a,
                                       input logic [7:0] b);
    case (op)
      OP_ADD:  return a + b;
      OP_CMP:  return ~b;
      OP_SHL:  return {b[6:0], 1'b0};
      OP_SHR:  return {b[7], b[7:1]};
      default: return b;
    endcase
  endfunction

  task automatic clear_img();
    for (int i = 0; i < 32; i++) img[i] = 8'h00;
  endtask

  task automatic readm(input int a, output logic [7:0] d);
    rd_addr = a[4:0];
    #1;
    d = rd_data;
  endtask

  task automatic run(output int cyc);
    rst_n   = 1'b0;
    load_we = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R3 acc during reset", acc, 0);
    chk("R3 halted during reset", halted, 0);
    for (int i = 0; i < 32; i++) begin
      load_we   = 1'b1;
      load_addr = i[4:0];
      load_data = img[i];
      @(negedge clk);
    end
    load_we = 1'b0;
    rst_n   = 1'b1;
    cyc     = 0;
    while (cyc < 4000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (halted) break;
    end
  endtask

  task automatic test_op(input opcode_e op, input logic [7:0] a, input logic [7:0] b);
    int cyc;
    logic [7:0] d, exp;
    clear_img();
    img[0]  = enc(OP_LDA, 16);
    img[1]  = enc(op, 17);
    img[2]  = enc(OP_STA, 18);
    img[3]  = enc(OP_HLT, 31);
    img[16] = a;
    img[17] = b;
    run(cyc);
    exp = model(op, a, b);
    readm(18, d);
    chk($sformatf("R4 R5 R6 R7 R8 stored result op=%0d", op), d, exp);
    chk($sformatf("R4 R6 R7 R8 accumulator op=%0d", op), acc, exp);
    chk("R11 cycles to halt", cyc, 33);
  endtask

  task automatic test_bnn(input logic [7:0] v);
    int cyc;
    logic [7:0] d;
    clear_img();
    img[0]  = enc(OP_LDA, 16);
    img[1]  = enc(OP_BNN, 6);
    img[2]  = enc(OP_LDA, 17);
    img[3]  = enc(OP_STA, 18);
    img[4]  = enc(OP_HLT, 0);
    img[6]  = enc(OP_LDA, 19);
    img[7]  = enc(OP_STA, 18);
    img[8]  = enc(OP_HLT, 0);
    img[16] = v;
    img[17] = 8'hAA;
    img[19] = 8'h55;
    run(cyc);
    readm(18, d);
    chk("R9 branch path", d, v[7] ? 8'hAA : 8'h55);
    chk("R11 branch cycles", cyc, 41);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    logic [7:0] d, acc_keep, mem_keep;
    opcode_e ops [5];
    rst_n     = 1'b0;
    load_we   = 1'b0;
    load_addr = '0;
    load_data = '0;
    rd_addr   = '0;
    ops[0] = OP_LDA; ops[1] = OP_ADD; ops[2] = OP_CMP; ops[3] = OP_SHL; ops[4] = OP_SHR;
    void'($urandom(32'd4051));

    // six plus three, stored at address 6
    clear_img();
    img[0] = enc(OP_LDA, 4);
    img[1] = enc(OP_ADD, 5);
    img[2] = enc(OP_STA, 6);
    img[3] = enc(OP_HLT, 31);
    img[4] = 8'd6;
    img[5] = 8'd3;
    run(cyc);
    readm(6, d);
    chk("R5 R6 sum stored", d, 9);
    chk("R5 accumulator", acc, 9);
    readm(4, d);
    chk("R1 loaded word read back", d, 6);
    chk("R3 R11 first program cycles", cyc, 33);
    chk("R10 halted raised", halted, 1);

    // frozen after halt, load port blocked (R2, R10)
    acc_keep = acc;
    readm(6, mem_keep);
    load_we   = 1'b1;
    load_addr = 5'd6;
    load_data = 8'h3C;
    repeat (20) @(negedge clk);
    load_we = 1'b0;
    readm(6, d);
    chk("R2 load ignored while running", d, mem_keep);
    chk("R10 accumulator frozen", acc, acc_keep);
    chk("R10 halted stays", halted, 1);

    // directed corners
    test_op(OP_ADD, 8'hF0, 8'h20);   // R6 wrap
    test_op(OP_SHR, 8'h00, 8'h81);   // R8 sign fill
    test_op(OP_SHL, 8'h00, 8'h81);   // R8 msb lost
    test_op(OP_CMP, 8'h12, 8'h00);   // R7
    test_bnn(8'h80);                 // R9 not taken
    test_bnn(8'h7F);                 // R9 taken

    // counter wrap: 0 -> 30 -> 31 -> 0 -> 1 (R12)
    clear_img();
    img[0]  = enc(OP_BNN, 30);
    img[1]  = enc(OP_HLT, 0);
    img[30] = enc(OP_LDA, 16);
    img[31] = enc(OP_STA, 18);
    img[16] = 8'h81;
    run(cyc);
    readm(18, d);
    chk("R12 wrap stored", d, 8'h81);
    chk("R12 wrap cycles", cyc, 41);

    // random operand pairs over all accumulator opcodes
    for (int k = 0; k < 30; k++) begin
      logic [7:0] a, b;
      opcode_e op;
      a  = 8'($urandom);
      b  = 8'($urandom);
      op = ops[$urandom % 5];
      test_op(op, a, b);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule